// File: doc/BRIEF.md
# SPI Slave Receiver With Sticky Status

This block is the slave side of a serial peripheral port. The block takes in characters on MOSI while the active-low select line is held low, and it returns a character on MISO during the same transfer. A character is between one and the maximum character width bits long; software picks the length in a control field. SCK, select and MOSI come from another clock domain. Each passes through a synchronizer, and the block then works on the SCK edges it detects, in clock mode 0. In that mode the block samples on the rising edge and changes MISO on the falling edge.

Software works through a small register port. Address 0 reads the last received character and writes the next character to send. Address 1 is control: bit 7 enables the block, bit 6 is a self-clearing start request, and the low bits hold the length code. Address 2 is the status register, whose event flags are cleared by writing ones to them. There are four event flags: character done or software start, overrun, bus collision, and select released in the middle of a character. The status register also shows two live bits: a character is partly shifted, and the level of the select line. The interrupt output is the done flag gated by the enable bit.

Top module: `spi_slave_stat`

## Requirements
- R1: After reset the status register reads 8'h01, control reads 8'h00, the interrupt output is 0 and MISO is 0. Status bits 3 and 2 always read 0.
- R2: While the enable bit (control bit 7) is 0, status reads 8'h01 and all four sticky flags are cleared. SCK and select activity while disabled sets no flag and stores no data.
- R3: When the configured number of bits has been sampled on rising SCK edges with select low, the character is stored in the data register, zero-extended and MSB first, and status bit 7 (interrupt) sets.
- R4: Length code 0 selects the full character width (8 bits); codes 1 to 7 select that number of bits.
- R5: Writing status with a bit set to 1 clears that flag (bits 7..4). Bits written as 0 leave their flags unchanged. A flag that is set and cleared in the same cycle ends up set.
- R6: Status bit 6 (overrun) sets when a character completes while the previous one has not yet been read from address 0.
- R7: When select rises after at least one bit but before the last bit of a character, status bit 4 (abort) and bit 7 both set, and the data register keeps its old value.
- R8: A rising SCK edge while select is high and the block is enabled sets status bit 5 (collision).
- R9: A control write with bit 6 set, while the block is already enabled, sets status bit 7. Control bit 6 always reads 0.
- R10: While enabled, status bit 0 reads 0 while select is low and 1 while it is high.
- R11: Status bit 1 reads 1 while a character is partly shifted and 0 otherwise.
- R12: The interrupt output equals status bit 7 ANDed with the enable bit.
- R13: MISO carries the transmit character MSB first. Its first bit appears after select falls, and it advances on each falling SCK edge within the character. MISO is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master, asynchronous |
| ss_n | input | 1 | Active-low slave select, asynchronous |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 consumes the character) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each SCK phase lasts longer than the synchronizer delay, so every edge is detected once. They also assume the length code is changed only while no character is partly shifted; otherwise the bit counter could sit beyond the new length. The stimulus holds every SCK phase for five system clocks. It writes control only while select is high. It waits six clocks after each select change before it reads status, so that the synchronized level has settled.

// File: rtl/spis_pkg.sv
package spis_pkg;

   typedef enum logic [1:0] {
      RA_DATA = 2'd0,
      RA_CTRL = 2'd1,
      RA_STAT = 2'd2,
      RA_NONE = 2'd3
   } spis_addr_e;

   localparam int CT_EN    = 7;
   localparam int CT_START = 6;

   localparam logic [7:0] STAT_RESET = 8'h01;

   typedef struct packed {
      logic irq;
      logic ovr;
      logic col;
      logic abt;
   } spis_flags_t;

   typedef struct packed {
      logic done;
      logic abort;
      logic collide;
   } spis_evt_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spis_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
   parameter int CHAR_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int LEN_W    = $clog2(CHAR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ss_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic [LEN_W-1:0]  len,
   input  logic [CHAR_W-1:0] txdata,
   output logic              miso,
   output logic              busy,
   output logic [CHAR_W-1:0] rxchar,
   output spis_pkg::spis_evt_t evt
);

   localparam logic [LEN_W:0] FULL_LEN = (LEN_W+1)'(CHAR_W);

   logic              ss_d, sck_d;
   logic              ss_fall, ss_rise, sck_rise, sck_fall;
   logic [LEN_W-1:0]  cnt;
   logic [LEN_W:0]    eff_len;
   logic              last;
   logic [CHAR_W-1:0] mask;
   logic [CHAR_W-1:0] rx_sh, rx_next;
   logic [CHAR_W-1:0] tx_sh, tx_load, tx_shifted;
   logic              miso_bit;
   logic              take_bit;

   assign ss_fall  = ss_d & ~ss_s;
   assign ss_rise  = ~ss_d & ss_s;
   assign sck_rise = ~sck_d & sck_s;
   assign sck_fall = sck_d & ~sck_s;

   assign eff_len  = (len == '0) ? FULL_LEN : {1'b0, len};
   assign last     = ({1'b0, cnt} == (eff_len - 1'b1));
   assign take_bit = en & ~ss_s & ~ss_fall & sck_rise;

   always_comb begin
      for (int i = 0; i < CHAR_W; i++) mask[i] = (i < int'(eff_len));
   end

   if (MSB_FIRST) begin : g_msb
      assign rx_next    = (rx_sh << 1) | CHAR_W'(mosi_s);
      assign tx_load    = txdata << (FULL_LEN - eff_len);
      assign tx_shifted = tx_sh << 1;
      assign miso_bit   = tx_sh[CHAR_W-1];
   end else begin : g_lsb
      always_comb begin
         rx_next      = rx_sh;
         rx_next[cnt] = mosi_s;
      end
      assign tx_load    = txdata;
      assign tx_shifted = tx_sh >> 1;
      assign miso_bit   = tx_sh[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_d  <= 1'b1;
         sck_d <= 1'b0;
         cnt   <= '0;
         rx_sh <= '0;
         tx_sh <= '0;
      end else begin
         ss_d  <= ss_s;
         sck_d <= sck_s;
         if (!en) begin
            cnt   <= '0;
            tx_sh <= '0;
         end else if (ss_fall) begin
            cnt   <= '0;
            tx_sh <= tx_load;
         end else if (ss_rise) begin
            cnt <= '0;
         end else if (take_bit) begin
            rx_sh <= rx_next;
            if (last) begin
               cnt   <= '0;
               tx_sh <= tx_load;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (!ss_s && sck_fall && cnt != '0) begin
            tx_sh <= tx_shifted;
         end
      end
   end

   assign evt.done    = take_bit & last;
   assign evt.abort   = en & ss_rise & (cnt != '0);
   assign evt.collide = en & ss_s & sck_rise;
   assign busy        = (cnt != '0);
   assign rxchar      = rx_next & mask;
   assign miso        = en & ~ss_s & miso_bit;

   // R4: counter never runs past the selected length
   a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < eff_len));

   // R11: partial character is dropped once select has been released
   a_r11_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ss_s) |=> !busy);

   // R2: disabled block holds no partial character
   a_r2_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

endmodule

// File: rtl/spis_status.sv
module spis_status (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  spis_pkg::spis_evt_t evt,
   input  logic                start_req,
   input  logic                rd_data,
   input  logic                wr_stat,
   input  logic [3:0]          clr,
   input  logic                busy,
   input  logic                ss_s,
   output logic [7:0]          stat,
   output logic                irq_flag
);
   import spis_pkg::*;

   spis_flags_t fl;
   logic        full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl   <= '0;
         full <= 1'b0;
      end else if (!en) begin
         fl   <= '0;
         full <= 1'b0;
      end else begin
         fl.irq <= (fl.irq & ~(wr_stat & clr[3])) | evt.done | evt.abort | start_req;
         fl.ovr <= (fl.ovr & ~(wr_stat & clr[2])) | (evt.done & full & ~rd_data);
         fl.col <= (fl.col & ~(wr_stat & clr[1])) | evt.collide;
         fl.abt <= (fl.abt & ~(wr_stat & clr[0])) | evt.abort;
         full   <= evt.done | (full & ~rd_data);
      end
   end

   assign stat     = {fl.irq, fl.ovr, fl.col, fl.abt, 2'b00, en & busy, en ? ss_s : 1'b1};
   assign irq_flag = fl.irq;

   // R7: abort raises both abort and interrupt flags
   a_r7_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt.abort) |=> (fl.abt && fl.irq));

   // R5: write-one clears the abort flag when no new abort arrives
   a_r5_w1c_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && clr[0] && !evt.abort) |=> !fl.abt);

   // R6: completion into an unread character flags overrun
   a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt.done && full && !rd_data) |=> fl.ovr);

   // R8: collision event is latched
   a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt.collide) |=> fl.col);

   // R9: start request latches the interrupt flag
   a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
      (en && start_req) |=> fl.irq);

   // R2: disabling clears every sticky flag
   a_r2_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (fl == '0 && !full));

endmodule

// File: rtl/spi_slave_stat.sv
module spi_slave_stat #(
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       ss_n,
   input  logic       mosi,
   output logic       miso,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq
);
   import spis_pkg::*;

   localparam int LEN_W = $clog2(CHAR_W);

   if (CHAR_W < 2 || CHAR_W > 8 || (1 << LEN_W) != CHAR_W) begin : g_bad_width
      $error("CHAR_W must be 2, 4 or 8");
   end

   logic [2:0]        sync_q;
   logic              sck_s, ss_s, mosi_s;
   logic              en_q;
   logic [LEN_W-1:0]  len_q;
   logic [CHAR_W-1:0] txdata_q, rxdata_q, rxchar;
   logic              busy, irq_flag, start_req, rd_data, wr_stat;
   logic [7:0]        stat, ctrl_rd;
   spis_evt_t         evt;

   spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck, ss_n, mosi}), .q(sync_q)
   );
   assign {sck_s, ss_s, mosi_s} = sync_q;

   assign start_req = reg_wr & (reg_addr == RA_CTRL) & reg_wdata[CT_START];
   assign rd_data   = reg_rd & (reg_addr == RA_DATA);
   assign wr_stat   = reg_wr & (reg_addr == RA_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         len_q    <= '0;
         txdata_q <= '0;
         rxdata_q <= '0;
      end else begin
         if (reg_wr && reg_addr == RA_CTRL) begin
            en_q  <= reg_wdata[CT_EN];
            len_q <= reg_wdata[LEN_W-1:0];
         end
         if (reg_wr && reg_addr == RA_DATA) txdata_q <= reg_wdata[CHAR_W-1:0];
         if (evt.done) rxdata_q <= rxchar;
      end
   end

   spis_shift #(.CHAR_W(CHAR_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en_q), .ss_s(ss_s), .sck_s(sck_s),
      .mosi_s(mosi_s), .len(len_q), .txdata(txdata_q), .miso(miso),
      .busy(busy), .rxchar(rxchar), .evt(evt)
   );

   spis_status u_stat (
      .clk(clk), .rst_n(rst_n), .en(en_q), .evt(evt), .start_req(start_req),
      .rd_data(rd_data), .wr_stat(wr_stat), .clr(reg_wdata[7:4]),
      .busy(busy), .ss_s(ss_s), .stat(stat), .irq_flag(irq_flag)
   );

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[CT_EN]       = en_q;
      ctrl_rd[LEN_W-1:0]   = len_q;
   end

   always_comb begin
      case (reg_addr)
         RA_DATA: reg_rdata = 8'(rxdata_q);
         RA_CTRL: reg_rdata = ctrl_rd;
         RA_STAT: reg_rdata = stat;
         default: reg_rdata = 8'h00;
      endcase
   end

   assign irq = irq_flag & en_q;

   // R3: a completed character lands in the data register
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      evt.done |=> (rxdata_q == $past(rxchar)));

   // R7: an aborted character does not touch the data register
   a_r7_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.abort && !evt.done) |=> $stable(rxdata_q));

endmodule

// File: tb/tb_spi_slave_stat.sv
module tb_spi_slave_stat;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq;

   int vectors = 0;
   int misses  = 0;

   always #2 clk = ~clk;

   spi_slave_stat dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [2:0] len;
      logic [7:0] mosi_v;
      logic [7:0] tx_v;
      logic [7:0] exp_rx;
      logic [7:0] exp_miso;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{3'd0, 8'h3C, 8'hA5, 8'h3C, 8'hA5},
      '{3'd4, 8'h0B, 8'h06, 8'h0B, 8'h06},
      '{3'd1, 8'h01, 8'h00, 8'h01, 8'h00},
      '{3'd7, 8'h55, 8'h2A, 8'h55, 8'h2A},
      '{3'd3, 8'h05, 8'h03, 8'h05, 8'h03},
      '{3'd0, 8'hFF, 8'h00, 8'hFF, 8'h00}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ss(input logic v);
      @(negedge clk);
      ss_n = v;
      wait_clk(6);
   endtask

   task automatic send(input logic [7:0] val, input int n, output logic [7:0] cap);
      cap = 8'h00;
      for (int i = n - 1; i >= 0; i--) begin
         mosi = val[i];
         wait_clk(5);
         cap[i] = miso;
         sck = 1'b1;
         wait_clk(5);
         sck = 1'b0;
      end
      wait_clk(5);
   endtask

   task automatic pulse_sck();
      @(negedge clk);
      sck = 1'b1;
      wait_clk(5);
      sck = 1'b0;
      wait_clk(5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      misses++;
      vectors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [7:0] v, cap;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);

      // R1 reset state
      rd(2'd2, v); chk("R1 status after reset", v, 8'h01);
      rd(2'd1, v); chk("R1 control after reset", v, 8'h00);
      chk("R1 irq after reset", {7'd0, irq}, 8'h00);
      chk("R1 miso after reset", {7'd0, miso}, 8'h00);

      // Table walk: R3 R4 R13 R12
      for (int k = 0; k < 6; k++) begin
         int nb;
         nb = (VECS[k].len == 3'd0) ? 8 : int'(VECS[k].len);
         wr(2'd1, {1'b1, 4'b0, VECS[k].len});
         wr(2'd0, VECS[k].tx_v);
         set_ss(1'b0);
         send(VECS[k].mosi_v, nb, cap);
         set_ss(1'b1);
         rd(2'd2, v); chk("R3 status after character", v, 8'h81);
         chk("R12 irq after character", {7'd0, irq}, 8'h01);
         rd(2'd0, v); chk("R4 received character", v, VECS[k].exp_rx);
         chk("R13 miso bit sequence", cap, VECS[k].exp_miso);
         wr(2'd2, 8'h80);
         rd(2'd2, v); chk("R5 irq cleared", v, 8'h01);
      end

      // R6 overrun: two 4-bit characters, no read between
      wr(2'd1, 8'h84);
      set_ss(1'b0);
      send(8'h0A, 4, cap);
      send(8'h03, 4, cap);
      set_ss(1'b1);
      rd(2'd2, v); chk("R6 overrun status", v, 8'hC1);
      rd(2'd0, v); chk("R6 latest character kept", v, 8'h03);
      wr(2'd2, 8'hF0);

      // R7 R10 R11 abort mid-character
      wr(2'd1, 8'h80);
      set_ss(1'b0);
      rd(2'd2, v); chk("R10 select low reads 0", v, 8'h00);
      send(8'h05, 3, cap);
      rd(2'd2, v); chk("R11 transfer in progress", v, 8'h02);
      set_ss(1'b1);
      rd(2'd2, v); chk("R7 abort status", v, 8'h91);
      rd(2'd0, v); chk("R7 data unchanged by abort", v, 8'h03);
      wr(2'd2, 8'hF0);

      // R8 collision
      pulse_sck();
      rd(2'd2, v); chk("R8 collision status", v, 8'h21);
      chk("R12 no irq on collision", {7'd0, irq}, 8'h00);

      // R2 disable clears and ignores activity
      wr(2'd1, 8'h00);
      rd(2'd2, v); chk("R2 disabled status", v, 8'h01);
      set_ss(1'b0);
      send(8'hFF, 8, cap);
      rd(2'd2, v); chk("R2 disabled ignores select", v, 8'h01);
      chk("R13 miso quiet when disabled", cap, 8'h00);
      set_ss(1'b1);
      wr(2'd1, 8'h80);
      rd(2'd2, v); chk("R2 no flags from disabled activity", v, 8'h01);
      rd(2'd0, v); chk("R2 no data from disabled activity", v, 8'h03);

      // R9 start request, R5 write-zero and mixed clears
      wr(2'd1, 8'hC0);
      rd(2'd2, v); chk("R9 start sets irq", v, 8'h81);
      rd(2'd1, v); chk("R9 start reads 0", v, 8'h80);
      chk("R12 irq output on start", {7'd0, irq}, 8'h01);
      wr(2'd2, 8'h00);
      rd(2'd2, v); chk("R5 write zero keeps flag", v, 8'h81);
      wr(2'd2, 8'h7F);
      rd(2'd2, v); chk("R5 other ones keep irq", v, 8'h81);
      wr(2'd2, 8'h80);
      rd(2'd2, v); chk("R5 write one clears irq", v, 8'h01);
      chk("R12 irq output cleared", {7'd0, irq}, 8'h00);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule